// File: doc/BRIEF.md
# Asynchronous Parallel Bus Master with Wait States

This block turns single-byte read and write requests from inside the chip into cycles on an asynchronous parallel peripheral bus. The bus has a 12-bit address, 8 data bits, a read/write line, an active-low chip select and a Ready input. A peripheral pulls Ready low to stretch a cycle. All bus timing comes from counting cycles of the fast system clock. That clock is nominally 100 MHz, so one cycle is 10 ns. The counts cover address setup, chip-select width, post-Ready hold and address hold. Each count is a parameter, derived from the nanosecond figures by rounding up.

A request names a 16-bit internal offset. Only offsets in the 4096-byte master window (upper nibble 0x1) are carried to the bus, and only while the operating-mode input selects bus-master mode. Any other request ends at once with an error response, and no bus cycle takes place. Ready passes through a synchronizer before the control logic sees it. If a peripheral holds Ready low too long, a timeout releases chip select and reports an error.

Top module: `abm_bus_master`

## Requirements
- R1: After reset, chip select is high (inactive), the data drivers are off, `req_ready` is 1, `rsp_valid` is 0 and the bus address is 0.
- R2: A request accepted at clock edge 0 puts its low 12 address bits on `bus_addr` and sets `bus_rw` (1 = read, 0 = write) after that edge. Chip select falls at edge SETUP_CYC. Address and `bus_rw` do not change while chip select is low.
- R3: While Ready stays high, chip select stays low for exactly DECIDE_CYC cycles. DECIDE_CYC is the larger of STROBE_CYC and RDY_WIN_CYC plus the synchronizer depth. A Ready low pulse that has cleared the synchronizer before the decision edge does not stretch the cycle.
- R4: A write drives `req_wdata` on `bus_dout` with `bus_doe` = 1 from edge 0 until the response edge. A read never sets `bus_doe`.
- R5: A read captures `bus_din` on the edge at which chip select rises, and returns it on `rsp_rdata`. A write returns `rsp_rdata` = 0.
- R6: If synchronized Ready is low at the decision edge, the cycle waits. It continues until synchronized Ready is seen high. Chip select then rises POST_RD_CYC edges later for a read, or POST_WR_CYC edges later for a write.
- R7: Address and data stay unchanged for HOLD_CYC edges after chip select rises. Then `rsp_valid` pulses for one cycle, `bus_doe` drops and `req_ready` returns to 1.
- R8: A request whose offset lies outside 0x1000–0x1FFF, or that arrives while `mode_sel` is not 3'b000, causes no bus activity. It is answered on the next edge with `rsp_valid` = 1, `rsp_err` = 1 and `rsp_rdata` = 0.
- R9: If synchronized Ready stays low for TIMEOUT_CYC edges after the decision edge, chip select rises on that edge. The response carries `rsp_err` = 1 and `rsp_rdata` = 0. If Ready is seen high on that same edge, it takes precedence over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Operating mode; 3'b000 enables bus-master accesses |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Internal offset of the byte |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an error (rejected or timed out) |
| rsp_rdata | output | 8 | Read byte |
| bus_addr | output | 12 | Bus address |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_dout | output | 8 | Data driven towards the peripheral |
| bus_doe | output | 1 | Output enable of the data pad |
| bus_din | input | 8 | Data from the peripheral pad |
| bus_rdy | input | 1 | Asynchronous Ready from the peripheral, low = wait |

## Verification
The bench builds the block with short counts: SETUP_CYC 2, STROBE_CYC 6, RDY_WIN_CYC 3, POST_RD_CYC 2, POST_WR_CYC 3, HOLD_CYC 1 and TIMEOUT_CYC 20. With these values the decision edge lands at edge 8, and a full timeout fits in about thirty cycles. Each phase boundary can then be placed to the exact edge. This covers a Ready pulse absorbed just before the decision, the shortest possible stretch, and Ready returning on the very edge the timeout would fire. The reference model works out the chip-select rise edge from the Ready waveform the bench applies, and checks every output on every clock.

// File: rtl/abm_pkg.sv
package abm_pkg;
  localparam logic [2:0] MODE_BUS_MASTER = 3'b000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_POST,
    ST_HOLD
  } abm_state_e;
endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RESET_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/abm_decode.sv
module abm_decode #(
  parameter int                PAGE_W   = 4,
  parameter logic [PAGE_W-1:0] WIN_PAGE = 4'h1
) (
  input  logic [2:0]        mode,
  input  logic [PAGE_W-1:0] page,
  output logic              ok
);
  import abm_pkg::*;

  always_comb begin
    ok = (mode == MODE_BUS_MASTER) && (page == WIN_PAGE);
  end
endmodule

// File: rtl/abm_bus_master.sv
module abm_bus_master #(
  parameter int               IN_AW       = 16,
  parameter int               BUS_AW      = 12,
  parameter int               DW          = 8,
  parameter logic [IN_AW-1:0] WIN_BASE    = 16'h1000,
  parameter int               SYNC_STAGES = 2,
  parameter int               SETUP_CYC   = 1,
  parameter int               STROBE_CYC  = 22,
  parameter int               RDY_WIN_CYC = 12,
  parameter int               POST_RD_CYC = 1,
  parameter int               POST_WR_CYC = 6,
  parameter int               HOLD_CYC    = 1,
  parameter int               TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IN_AW-1:0]  req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic [BUS_AW-1:0] bus_addr,
  output logic              bus_rw,
  output logic              bus_cs_n,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din,
  input  logic              bus_rdy
);
  import abm_pkg::*;

  localparam int PAGE_W     = IN_AW - BUS_AW;
  localparam int RDY_SEEN   = RDY_WIN_CYC + SYNC_STAGES;
  localparam int DECIDE_CYC = (STROBE_CYC > RDY_SEEN) ? STROBE_CYC : RDY_SEEN;
  localparam int CNT_SPAN   = SETUP_CYC + DECIDE_CYC + POST_RD_CYC + POST_WR_CYC + HOLD_CYC;
  localparam int CW         = $clog2(CNT_SPAN + 1);
  localparam int TW         = $clog2(TIMEOUT_CYC + 1);

  abm_state_e      state;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tcnt;
  logic            rdy_s;
  logic            acc_ok;
  logic            err_q;
  logic [DW-1:0]   cap_q;

  abm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rdy_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_rdy),
    .q   (rdy_s)
  );

  abm_decode #(.PAGE_W(PAGE_W), .WIN_PAGE(WIN_BASE[IN_AW-1:BUS_AW])) u_decode (
    .mode (mode_sel),
    .page (req_addr[IN_AW-1:BUS_AW]),
    .ok   (acc_ok)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      tcnt      <= '0;
      err_q     <= 1'b0;
      cap_q     <= '0;
      bus_addr  <= '0;
      bus_rw    <= 1'b1;
      bus_cs_n  <= 1'b1;
      bus_dout  <= '0;
      bus_doe   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!acc_ok) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end else begin
              bus_addr <= req_addr[BUS_AW-1:0];
              bus_rw   <= !req_write;
              bus_dout <= req_wdata;
              bus_doe  <= req_write;
              err_q    <= 1'b0;
              cnt      <= CW'(SETUP_CYC - 1);
              state    <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            bus_cs_n <= 1'b0;
            cnt      <= CW'(DECIDE_CYC - 1);
            state    <= ST_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (rdy_s) begin
            bus_cs_n <= 1'b1;
            cap_q    <= bus_din;
            cnt      <= CW'(HOLD_CYC - 1);
            state    <= ST_HOLD;
          end else begin
            tcnt  <= '0;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rdy_s) begin
            cnt   <= bus_rw ? CW'(POST_RD_CYC - 1) : CW'(POST_WR_CYC - 1);
            state <= ST_POST;
          end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
            bus_cs_n <= 1'b1;
            err_q    <= 1'b1;
            cap_q    <= '0;
            cnt      <= CW'(HOLD_CYC - 1);
            state    <= ST_HOLD;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_POST: begin
          if (cnt == '0) begin
            bus_cs_n <= 1'b1;
            cap_q    <= bus_din;
            cnt      <= CW'(HOLD_CYC - 1);
            state    <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            bus_doe   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= err_q;
            rsp_rdata <= (bus_rw && !err_q) ? cap_q : '0;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abm_bus_master_chk.sv
module abm_bus_master_chk #(
  parameter int BUS_AW      = 12,
  parameter int DW          = 8,
  parameter int DECIDE_CYC  = 22,
  parameter int LOW_BOUND   = 1100
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode_sel,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_rw,
  input logic              bus_cs_n,
  input logic [DW-1:0]     bus_dout,
  input logic              bus_doe
);
  int lowcnt;

  always_ff @(posedge clk) begin
    if (rst)            lowcnt <= 0;
    else if (!bus_cs_n) lowcnt <= lowcnt + 1;
    else                lowcnt <= 0;
  end

  a_r2_addr_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cs_n) |-> ($stable(bus_addr) && $stable(bus_rw)));

  a_r2_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_rw)));

  a_r3_cs_min_width: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> (lowcnt >= DECIDE_CYC));

  a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> !bus_rw);

  a_r7_hold_after_cs: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> ($stable(bus_addr) && $stable(bus_doe) && $stable(bus_dout)));

  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r8_reject_mode: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (mode_sel != 3'b000)) |=> (rsp_valid && rsp_err && bus_cs_n));

  a_r9_cs_bounded: assert property (@(posedge clk) disable iff (rst)
    lowcnt <= LOW_BOUND);
endmodule

bind abm_bus_master abm_bus_master_chk #(
  .BUS_AW     (BUS_AW),
  .DW         (DW),
  .DECIDE_CYC (DECIDE_CYC),
  .LOW_BOUND  (DECIDE_CYC + TIMEOUT_CYC + POST_RD_CYC + POST_WR_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_sel  (mode_sel),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .bus_addr  (bus_addr),
  .bus_rw    (bus_rw),
  .bus_cs_n  (bus_cs_n),
  .bus_dout  (bus_dout),
  .bus_doe   (bus_doe)
);

// File: tb/abm_bus_master_test.sv
module abm_bus_master_test;
  localparam int S  = 2;
  localparam int SW = 6;
  localparam int RW = 3;
  localparam int PR = 2;
  localparam int PW = 3;
  localparam int H  = 1;
  localparam int T  = 20;
  localparam int D  = (SW > RW + 2) ? SW : RW + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_sel = 3'b000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [7:0]  rsp_rdata;
  logic [11:0] bus_addr;
  logic        bus_rw;
  logic        bus_cs_n;
  logic [7:0]  bus_dout;
  logic        bus_doe;
  logic [7:0]  bus_din = '0;
  logic        bus_rdy = 1'b1;

  int checks = 0;
  int errors = 0;
  int cur_lo = 0;
  int cur_r  = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  abm_bus_master #(
    .SETUP_CYC(S), .STROBE_CYC(SW), .RDY_WIN_CYC(RW), .POST_RD_CYC(PR),
    .POST_WR_CYC(PW), .HOLD_CYC(H), .TIMEOUT_CYC(T)
  ) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_cs_n(bus_cs_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit rplan(input int j);
    if (j < 0) return 1'b1;
    return (j >= cur_lo && j < cur_r) ? 1'b0 : 1'b1;
  endfunction

  task automatic run_txn(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                         input logic [2:0] md, input int lo, input int r,
                         input logic [7:0] din, input string tag);
    bit good;
    bit terr;
    int rise;
    int done;
    good = (md == 3'b000) && (a[15:12] == 4'h1);
    cur_lo = lo;
    cur_r  = r;
    rise = 0;
    if (!good) begin
      done = 0;
      terr = 1'b1;
    end else begin
      if (rplan(S + D - 2)) begin
        rise = S + D;
        terr = 1'b0;
      end else begin
        bit found = 1'b0;
        int e = S + D + 1;
        terr = 1'b0;
        while (!found) begin
          if (rplan(e - 2)) begin
            rise = e + (wr ? PW : PR);
            found = 1'b1;
          end else if (e == S + D + T) begin
            rise = e;
            terr = 1'b1;
            found = 1'b1;
          end
          e++;
        end
      end
      done = rise + H;
    end
    mode_sel  = md;
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    bus_din   = din;
    bus_rdy   = rplan(0);
    req_valid = 1'b1;
    for (int k = 0; k <= done + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      chk(bus_cs_n == !(good && k >= S && k < rise), tag, "cs_n",
          bus_cs_n, !(good && k >= S && k < rise));
      chk(bus_doe == (good && wr && k < done), "R4", "doe",
          bus_doe, (good && wr && k < done));
      if (good && wr && k < done) chk(bus_dout == wd, "R4", "dout", bus_dout, wd);
      if (good && k <= done) begin
        chk(bus_addr == a[11:0], "R2", "addr", bus_addr, a[11:0]);
        chk(bus_rw == !wr, "R2", "rw", bus_rw, !wr);
      end
      chk(rsp_valid == (k == done), "R7", "rsp_valid", rsp_valid, (k == done));
      chk(req_ready == (k >= done), "R7", "req_ready", req_ready, (k >= done));
      if (k == done) begin
        chk(rsp_err == terr, tag, "rsp_err", rsp_err, terr);
        chk(rsp_rdata == ((!wr && !terr) ? din : 8'h00), "R5", "rdata", rsp_rdata,
            (!wr && !terr) ? din : 8'h00);
      end
      bus_rdy = rplan(k + 1);
    end
    bus_rdy = 1'b1;
    mode_sel = 3'b000;
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(bus_cs_n == 1'b1, "R1", "cs_n", bus_cs_n, 1);
    chk(bus_doe == 1'b0, "R1", "doe", bus_doe, 0);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(bus_addr == 12'h000, "R1", "addr", bus_addr, 0);

    // R3 write and read without wait states
    run_txn(1'b1, 16'h1234, 8'h5C, 3'b000, 0, 0, 8'h00, "R3");
    run_txn(1'b0, 16'h1ABC, 8'h00, 3'b000, 0, 0, 8'hA5, "R3");
    // R3 short Ready pulse absorbed before the decision edge
    run_txn(1'b0, 16'h1001, 8'h00, 3'b000, 2, 4, 8'h3C, "R3");
    // R6 stretched read and write
    run_txn(1'b0, 16'h1FFF, 8'h00, 3'b000, 3, 12, 8'h96, "R6");
    run_txn(1'b1, 16'h1000, 8'hE7, 3'b000, 3, 12, 8'h00, "R6");
    // R6 shortest stretch
    run_txn(1'b1, 16'h1555, 8'h81, 3'b000, 3, 7, 8'h00, "R6");
    run_txn(1'b0, 16'h1AAA, 8'h00, 3'b000, 3, 7, 8'h42, "R6");
    // R9 timeout on read and write
    run_txn(1'b0, 16'h1100, 8'h00, 3'b000, 3, 200, 8'hFF, "R9");
    run_txn(1'b1, 16'h1200, 8'h11, 3'b000, 3, 200, 8'h00, "R9");
    // R9 Ready returns on the timeout edge and wins
    run_txn(1'b0, 16'h1300, 8'h00, 3'b000, 3, 26, 8'h6D, "R9");
    // R8 rejected requests
    run_txn(1'b0, 16'h2000, 8'h00, 3'b000, 0, 0, 8'h77, "R8");
    run_txn(1'b1, 16'h0FFF, 8'h99, 3'b000, 0, 0, 8'h00, "R8");
    run_txn(1'b1, 16'h1400, 8'h99, 3'b010, 0, 0, 8'h00, "R8");
    run_txn(1'b0, 16'h1400, 8'h00, 3'b001, 0, 0, 8'h12, "R8");
    // R8 bus untouched by rejection: address still from the last accepted access
    chk(bus_addr == 12'h300, "R8", "addr kept", bus_addr, 12'h300);
    // back-to-back after rejection
    run_txn(1'b1, 16'h1FFE, 8'hC3, 3'b000, 0, 0, 8'h00, "R3");

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule